// File: doc/BRIEF.md
# Pipelined Loop Branch Controller

This block steers a software-pipelined loop whose body is written once, as a kernel only. The schedule splits one iteration into S stages, and each stage of the kernel runs only while its own stage predicate is set. A start command loads the trip count N and the stage count S. Each loop-branch strobe then does three things. It decides whether the loop branch is taken. It rotates the predicate file by one place. It writes a one into the youngest predicate while iterations remain, or a zero while the pipe drains. The same kernel body therefore gives the ramp-up passes, the steady-state passes and the ramp-down passes.

The counters are held zero-relative: N is stored as N-1 and S as S-1. The predicate file is addressed through a rotation base. The physical slot of logical predicate k is (k + base) mod PRED_W, so stepping the base down by one moves every logical predicate up one place. The base is also exported so that a rotating register file outside the block can rename through it.

The controller has four states, and start is accepted in any of them. In ST_IDLE (after reset), strobes are ignored. Start moves the block to ST_LOOP, or to ST_DONE when N is zero. ST_LOOP stays in ST_LOOP on a fill strobe. It moves to ST_DRAIN on its first drain strobe, or to ST_DONE on a fall-through. ST_DRAIN moves to ST_DONE on the fall-through. ST_DONE holds until the next start.

Top module: `swp_loop_ctrl`

## Requirements
- R1: After reset, stage_en_o, rot_base_o, taken_o and done_o are all zero, and a branch strobe before any start changes none of them.
- R2: A start with iter_cnt_i = N >= 1 loads N-1 into the loop counter and S-1 into the drain counter (S = stage_cnt_i). It clears every predicate and sets logical predicate 0, so stage_en_o = 1. It sets rot_base_o to 0 and drops done_o. These values are visible from the cycle after start.
- R3: A strobe while the loop counter is nonzero makes taken_o high in that cycle. After the edge, the loop counter is one lower and rot_base_o is one lower (mod PRED_W). Every logical predicate k is moved to k+1, and logical predicate 0 becomes 1.
- R4: A strobe while the loop counter is zero and the drain counter is nonzero makes taken_o high. After the edge, the drain counter and rot_base_o are one lower, the predicates move up one place, and logical predicate 0 becomes 0.
- R5: A strobe with both counters zero falls through. In that cycle, taken_o is low and done_o is high. done_o then stays high until the next start.
- R6: Bit k of stage_en_o is logical predicate k. For N = 4 and S = 4, the low four bits in pass order, bit 0 first, read 1000, 1100, 1110, 1111, 0111, 0011, 0001.
- R7: A loop of N iterations and S stages runs N+S-1 kernel passes. That is N+S-2 taken strobes followed by one fall-through.
- R8: While done_o is high and start is low, a strobe has no effect: taken_o stays low, and stage_en_o and rot_base_o do not change.
- R9: A start with N = 0 makes done_o high from the next cycle and leaves stage_en_o all zero.
- R10: rot_base_o wraps modulo PRED_W, and S may be as large as PRED_W.
- R11: Start takes priority over a strobe in the same cycle and restarts a running loop from the R2 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load counts and initialise predicates |
| iter_cnt_i | input | CNT_W | Trip count N (natural, not zero-relative) |
| stage_cnt_i | input | $clog2(PRED_W)+1 | Stage count S, 1 to PRED_W |
| branch_i | input | 1 | Loop-branch strobe, one per kernel pass |
| stage_en_o | output | PRED_W | Logical predicates, bit k enables stage k |
| taken_o | output | 1 | Branch taken in the strobe cycle |
| done_o | output | 1 | Loop finished |
| rot_base_o | output | $clog2(PRED_W) | Current rotation base |

## Verification
The bench drives the hand-over from fill to drain. A design that checks the drain counter first, or that writes a one during the drain, would keep stage 0 alive after the last iteration. It covers loops with a single iteration and a single stage, where the first strobe must already fall through; an off-by-one in the zero-relative load would add a pass there. A long loop wraps the base past zero, and S = PRED_W uses every slot. Together these expose a base that saturates or an index that is taken without the modulo. The bench also gives strobes after done and at the same time as start, and a start with a trip count of zero. These catch a design that restarts by itself, ignores the start priority, or enables stage 0 when no iteration exists.

// File: rtl/swp_pkg.sv
package swp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOOP  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } swp_state_e;
endpackage

// File: rtl/swp_counters.sv
module swp_counters #(
    parameter int CNT_W = 16,
    parameter int SW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] iter_i,
    input  logic [SW-1:0]    stages_i,
    input  logic             dec_lc_i,
    input  logic             dec_esc_i,
    output logic             lc_zero_o,
    output logic             esc_zero_o
);
    logic [CNT_W-1:0] lc_q;
    logic [SW-1:0]    esc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lc_q  <= '0;
            esc_q <= '0;
        end else if (load_i) begin
            lc_q  <= (iter_i == '0)   ? '0 : iter_i - CNT_W'(1);
            esc_q <= (stages_i == '0) ? '0 : stages_i - SW'(1);
        end else begin
            if (dec_lc_i)  lc_q  <= lc_q - CNT_W'(1);
            if (dec_esc_i) esc_q <= esc_q - SW'(1);
        end
    end

    assign lc_zero_o  = (lc_q == '0);
    assign esc_zero_o = (esc_q == '0);
endmodule

// File: rtl/swp_pred_file.sv
module swp_pred_file #(
    parameter int PRED_W = 8,
    parameter int BW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              seed_i,
    input  logic              rotate_i,
    input  logic              new_bit_i,
    output logic [PRED_W-1:0] logical_o,
    output logic [BW-1:0]     base_o
);
    logic [PRED_W-1:0] phys_q;
    logic [BW-1:0]     base_q;
    logic [BW-1:0]     base_dn;

    assign base_dn = base_q - BW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phys_q <= '0;
            base_q <= '0;
        end else if (clear_i) begin
            phys_q    <= '0;
            phys_q[0] <= seed_i;
            base_q    <= '0;
        end else if (rotate_i) begin
            base_q          <= base_dn;
            phys_q[base_dn] <= new_bit_i;
        end
    end

    // logical predicate k lives in physical slot (k + base) mod PRED_W
    for (genvar k = 0; k < PRED_W; k++) begin : g_map
        logic [BW-1:0] slot;
        assign slot         = BW'(k) + base_q;
        assign logical_o[k] = phys_q[slot];
    end

    assign base_o = base_q;
endmodule

// File: rtl/swp_loop_ctrl.sv
module swp_loop_ctrl
    import swp_pkg::*;
#(
    parameter int PRED_W = 8,
    parameter int CNT_W  = 16,
    localparam int BW    = $clog2(PRED_W),
    localparam int SW    = BW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  iter_cnt_i,
    input  logic [SW-1:0]     stage_cnt_i,
    input  logic              branch_i,
    output logic [PRED_W-1:0] stage_en_o,
    output logic              taken_o,
    output logic              done_o,
    output logic [BW-1:0]     rot_base_o
);
    swp_state_e state_q, state_d;
    logic lc_zero, esc_zero;
    logic active, fill, drain, fall;
    logic seed;

    assign seed = (iter_cnt_i != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        active  = 1'b0;
        fill    = 1'b0;
        drain   = 1'b0;
        fall    = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOOP: begin
                active = branch_i && !start_i;
                fill   = active && !lc_zero;
                drain  = active && lc_zero && !esc_zero;
                fall   = active && lc_zero && esc_zero;
                if (drain)     state_d = ST_DRAIN;
                else if (fall) state_d = ST_DONE;
            end
            ST_DRAIN: begin
                active = branch_i && !start_i;
                drain  = active && !esc_zero;
                fall   = active && esc_zero;
                if (fall) state_d = ST_DONE;
            end
            ST_DONE: ;
            default: state_d = ST_IDLE;
        endcase
        if (start_i) state_d = seed ? ST_LOOP : ST_DONE;
    end

    always_comb begin
        taken_o = fill || drain;
        done_o  = (state_q == ST_DONE) || fall;
    end

    swp_counters #(.CNT_W(CNT_W), .SW(SW)) i_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start_i),
        .iter_i     (iter_cnt_i),
        .stages_i   (stage_cnt_i),
        .dec_lc_i   (fill),
        .dec_esc_i  (drain),
        .lc_zero_o  (lc_zero),
        .esc_zero_o (esc_zero)
    );

    swp_pred_file #(.PRED_W(PRED_W), .BW(BW)) i_pred (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_i),
        .seed_i    (seed),
        .rotate_i  (fill || drain),
        .new_bit_i (fill),
        .logical_o (stage_en_o),
        .base_o    (rot_base_o)
    );
endmodule

// File: rtl/swp_loop_ctrl_chk.sv
module swp_loop_ctrl_chk #(
    parameter int PRED_W = 8,
    parameter int CNT_W  = 16,
    parameter int BW     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [CNT_W-1:0]  iter_cnt_i,
    input logic              branch_i,
    input logic [PRED_W-1:0] stage_en_o,
    input logic              taken_o,
    input logic              done_o,
    input logic [BW-1:0]     rot_base_o
);
    AST_START_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && iter_cnt_i != '0 |=> stage_en_o == PRED_W'(1) && rot_base_o == '0 && !done_o); // R2

    AST_ZERO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && iter_cnt_i == '0 |=> done_o && stage_en_o == '0); // R9

    AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o && !start_i |=> stage_en_o[PRED_W-1:1] == $past(stage_en_o[PRED_W-2:0])); // R3

    AST_BASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o && !start_i |=> rot_base_o == BW'($past(rot_base_o) - BW'(1))); // R10

    AST_TAKEN_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(taken_o && done_o)); // R5

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> done_o && $stable(stage_en_o) && $stable(rot_base_o)); // R8
endmodule

bind swp_loop_ctrl swp_loop_ctrl_chk #(.PRED_W(PRED_W), .CNT_W(CNT_W), .BW(BW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .iter_cnt_i (iter_cnt_i),
    .branch_i   (branch_i),
    .stage_en_o (stage_en_o),
    .taken_o    (taken_o),
    .done_o     (done_o),
    .rot_base_o (rot_base_o)
);

// File: tb/test_swp_loop_ctrl.sv
`timescale 1ns/100ps
module test_swp_loop_ctrl;
    localparam int PW    = 8;
    localparam int CW    = 16;
    localparam int BW    = $clog2(PW);
    localparam int SW    = BW + 1;

    typedef struct {
        logic          taken;
        logic          done;
        logic [PW-1:0] en;
        logic [BW-1:0] base;
        string         req;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, branch_i = 1'b0;
    logic [CW-1:0] iter_cnt_i = '0;
    logic [SW-1:0] stage_cnt_i = '0;
    logic [PW-1:0] stage_en_o;
    logic taken_o, done_o;
    logic [BW-1:0] rot_base_o;

    int checks = 0, errors = 0, taken_seen = 0;
    bit finished = 0;
    exp_t q[$];

    // reference model state
    int m_lc = 0, m_esc = 0;
    logic [PW-1:0] m_pv = '0;
    logic [BW-1:0] m_base = '0;
    bit m_done = 0, m_idle = 1;

    always #2.5 clk = ~clk;

    swp_loop_ctrl #(.PRED_W(PW), .CNT_W(CW)) i_swp_loop_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .iter_cnt_i(iter_cnt_i),
        .stage_cnt_i(stage_cnt_i), .branch_i(branch_i), .stage_en_o(stage_en_o),
        .taken_o(taken_o), .done_o(done_o), .rot_base_o(rot_base_o)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: pops one expected item per strobe
    initial begin
        forever begin
            @(negedge clk);
            if (branch_i && !start_i) begin
                exp_t e;
                if (q.size() == 0) begin
                    check("R7", "unexpected strobe", 1, 0);
                end else begin
                    e = q.pop_front();
                    if (taken_o) taken_seen++;
                    check(e.req, "taken_o", taken_o, e.taken);
                    check(e.req, "done_o", done_o, e.done);
                    @(negedge clk);
                    check(e.req, "stage_en_o", stage_en_o, e.en);
                    check(e.req, "rot_base_o", rot_base_o, e.base);
                end
            end
        end
    end

    task automatic strobe();
        exp_t e;
        e.req = "R3";
        if (m_idle) begin
            e.taken = 0; e.done = 0; e.req = "R1";
        end else if (m_done) begin
            e.taken = 0; e.done = 1; e.req = "R8";
        end else if (m_lc > 0) begin
            m_lc--; m_base = m_base - BW'(1); m_pv = {m_pv[PW-2:0], 1'b1};
            e.taken = 1; e.done = 0; e.req = "R3";
        end else if (m_esc > 0) begin
            m_esc--; m_base = m_base - BW'(1); m_pv = {m_pv[PW-2:0], 1'b0};
            e.taken = 1; e.done = 0; e.req = "R4";
        end else begin
            m_done = 1; e.taken = 0; e.done = 1; e.req = "R5";
        end
        e.en = m_pv; e.base = m_base;
        @(posedge clk); #1;
        branch_i = 1'b1;
        q.push_back(e);
        @(posedge clk); #1;
        branch_i = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic start(input int n, input int s, input bit with_branch, input string req);
        @(posedge clk); #1;
        start_i = 1'b1; iter_cnt_i = CW'(n); stage_cnt_i = SW'(s); branch_i = with_branch;
        @(posedge clk); #1;
        start_i = 1'b0; branch_i = 1'b0;
        m_idle = 0; taken_seen = 0;
        if (n == 0) begin
            m_done = 1; m_pv = '0;
        end else begin
            m_done = 0; m_lc = n - 1; m_esc = (s == 0) ? 0 : s - 1; m_pv = PW'(1);
        end
        m_base = '0;
        @(negedge clk);
        check(req, "start stage_en_o", stage_en_o, m_pv);
        check(req, "start rot_base_o", rot_base_o, m_base);
        check(req, "start done_o", done_o, m_done);
    endtask

    task automatic run_loop(input int n, input int s, input string req);
        start(n, s, 0, req);
        for (int i = 0; i < n + s - 1; i++) strobe();
        @(negedge clk);
        check("R7", "taken count", taken_seen, n + s - 2);
        check("R5", "done after loop", done_o, 1);
    endtask

    initial begin
        #10000000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hang expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset stage_en_o", stage_en_o, 0);
        check("R1", "reset rot_base_o", rot_base_o, 0);
        check("R1", "reset done_o", done_o, 0);
        check("R1", "reset taken_o", taken_o, 0);
        strobe();                               // R1: strobe before start ignored

        // R6: fixed sequence for 4 iterations, 4 stages
        start(4, 4, 0, "R2");
        begin
            logic [3:0] seq [7] = '{4'b0001, 4'b0011, 4'b0111, 4'b1111, 4'b1110, 4'b1100, 4'b1000};
            for (int i = 0; i < 7; i++) begin
                check("R6", "pass enable", stage_en_o[3:0], seq[i]);
                strobe();
            end
        end
        check("R5", "done held", done_o, 1);
        strobe();                               // R8: ignored after done
        strobe();

        run_loop(1, 1, "R2");                   // first strobe falls through
        run_loop(3, 1, "R2");
        run_loop(1, 4, "R2");
        run_loop(20, 3, "R10");                 // base wraps several times
        run_loop(5, PW, "R10");                 // every slot used

        start(0, 3, 0, "R9");
        strobe();                               // R8: still ignored
        check("R9", "zero trip enables", stage_en_o, 0);

        // R11: restart mid-loop, and start together with a strobe
        start(6, 3, 0, "R2");
        strobe(); strobe();
        start(2, 2, 1, "R11");
        for (int i = 0; i < 3; i++) strobe();
        @(negedge clk);
        check("R11", "done after restart", done_o, 1);

        repeat (4) @(posedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule